// File: doc/BRIEF.md
# Microcoded Arithmetic Control Sequencer

This block evaluates a control law, for example a PID loop, with one small programmable datapath. It does not use a separate hardwired multiplier-adder tree for each term. A stored list of 16-bit microwords drives the datapath one instruction per clock. Each microword picks one operand from an A register bank and one from a B register bank. It applies one operator (add, multiply, clamp, or pass-through) and writes the result back into one of a fixed set of working registers. Subtraction takes two steps: the block multiplies by a stored -1 constant and then adds.

A run begins when a new setpoint/measurement pair arrives with a start strobe. The setpoint lands in A[5] and the measurement in A[6]. The first `NUM_INSTR` words of the instruction memory then execute in address order. When they finish, the content of B[1] is registered onto the duty output and a one-cycle done pulse marks the update. The instruction memory can be rewritten at any time through a simple write port, so the algorithm can change without touching the datapath. Values are signed Q16.16 fixed point.

Top module: `ctlseq_top`

## Requirements
- R1: While reset is held low, `pwmOut` reads 0 and `done` reads 0.
- R2: A `start` seen while idle loads `wIn` into A[5] and `yIn` into A[6]. Instructions at addresses 0 to NUM_INSTR-1 then run, one per clock. `pwmOut` takes B[1], and `done` is high for exactly one cycle, on the NUM_INSTR+2-th clock edge counted from the edge that sampled `start`.
- R3: Operator code 1 writes A+B. The result saturates to 0x7FFFFFFF on positive overflow and to 0x80000000 on negative overflow.
- R4: Operator code 2 writes bits [47:16] of the signed 64-bit product A*B. The result saturates to 0x7FFFFFFF or 0x80000000 when the true value does not fit in 32 bits.
- R5: Operator code 3 clamps B to [MIN_LIM, MAX_LIM]. Values below the range give MIN_LIM, values above it give MAX_LIM, and values inside it (limits included) pass unchanged.
- R6: Operator code 4 writes A, and operator code 5 writes B.
- R7: Operator code 0 and the reserved codes 6 to 15 write no register.
- R8: Microword bits [15:12] select A, bits [11:8] select B, bits [7:4] give the destination, and bits [3:0] give the operator. Destination codes 0..14 write B8, B7, B1, B6, A7, A8, A9, B2, B3, B9, B10, A10, B11, B4, B5 in that order. Code 15 writes nothing.
- R9: A value written by one instruction is the operand seen by the very next instruction.
- R10: A `start` that arrives while a run is in progress is ignored. It does not reload the inputs, restart the sequence, or add a done pulse.
- R11: Words written through `imemWe`/`imemAddr`/`imemData` replace the program, and the next run executes the new words.
- R12: A[1..4] hold the parameters KI, KD, KF and KP. A[11], A[12] and A[13] hold -1.0, +1.0 and 0, and so do B[12], B[13] and B[14]. No destination code can alter any of these registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | New sample pair strobe; starts a run when idle |
| wIn | input | 32 | Setpoint sample, Q16.16 |
| yIn | input | 32 | Measurement sample, Q16.16 |
| imemWe | input | 1 | Instruction memory write enable |
| imemAddr | input | $clog2(IMEM_DEPTH) | Instruction memory write address |
| imemData | input | 16 | Microword to write |
| pwmOut | output | 32 | Registered duty result (B[1] at end of run) |
| done | output | 1 | One-cycle pulse when `pwmOut` updates |

## Verification
A two-word program moves the measurement into the B bank and then combines it with the setpoint. A table of operand pairs drives this program through every operator. The pairs include small fractional values that expose scaling errors, values at both overflow edges that separate wrapping from saturation, and values below, inside, at, and above the clamp limits. A fifteen-step move chain passes the setpoint through every destination code in turn. This chain catches both a wrong destination map and any lost back-to-back forwarding. Directed programs cover the reserved and no-write codes, subtraction through the -1 constant, the gain constants, a second start during a run, and a program rewrite between runs.

// File: rtl/ctlseq_pkg.sv
package ctlseq_pkg;

  typedef logic signed [31:0] q16_t;

  localparam logic [3:0] OP_NOP   = 4'd0;
  localparam logic [3:0] OP_ADD   = 4'd1;
  localparam logic [3:0] OP_MUL   = 4'd2;
  localparam logic [3:0] OP_SAT   = 4'd3;
  localparam logic [3:0] OP_PASSA = 4'd4;
  localparam logic [3:0] OP_PASSB = 4'd5;

  localparam q16_t Q_POS_MAX = 32'sh7FFF_FFFF;
  localparam q16_t Q_NEG_MAX = 32'sh8000_0000;
  localparam q16_t Q_ONE     = 32'sh0001_0000;
  localparam q16_t Q_NEG_ONE = 32'shFFFF_0000;

  typedef struct packed {
    logic [3:0] aSel;
    logic [3:0] bSel;
    logic [3:0] dest;
    logic [3:0] op;
  } microWord_t;

  // strobes from the sequencer control to the datapath
  typedef struct packed {
    logic       loadIn;
    logic       exec;
    logic       capture;
    microWord_t word;
  } ctlStrobe_t;

  typedef struct packed {
    logic       valid;
    logic       toA;
    logic [3:0] idx;
  } destSlot_t;

  function automatic destSlot_t mapDest(input logic [3:0] code);
    destSlot_t s;
    s.valid = 1'b1;
    s.toA   = 1'b0;
    s.idx   = 4'd0;
    case (code)
      4'd0:  s.idx = 4'd8;
      4'd1:  s.idx = 4'd7;
      4'd2:  s.idx = 4'd1;
      4'd3:  s.idx = 4'd6;
      4'd4:  begin s.toA = 1'b1; s.idx = 4'd7;  end
      4'd5:  begin s.toA = 1'b1; s.idx = 4'd8;  end
      4'd6:  begin s.toA = 1'b1; s.idx = 4'd9;  end
      4'd7:  s.idx = 4'd2;
      4'd8:  s.idx = 4'd3;
      4'd9:  s.idx = 4'd9;
      4'd10: s.idx = 4'd10;
      4'd11: begin s.toA = 1'b1; s.idx = 4'd10; end
      4'd12: s.idx = 4'd11;
      4'd13: s.idx = 4'd4;
      4'd14: s.idx = 4'd5;
      default: s.valid = 1'b0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ctlseq_ctrl.sv
module ctlseq_ctrl
  import ctlseq_pkg::*;
#(
  parameter int NUM_INSTR  = 22,
  parameter int IMEM_DEPTH = 32,
  localparam int AW = $clog2(IMEM_DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          imemWe,
  input  logic [AW-1:0] imemAddr,
  input  logic [15:0]   imemData,
  output ctlStrobe_t    strobe,
  output logic          done
);

  localparam logic [AW-1:0] LAST_PC = AW'(NUM_INSTR - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} seqState_t;

  seqState_t   state;
  logic [AW-1:0] pc;
  logic [15:0] imem [IMEM_DEPTH];

  always_ff @(posedge clk) begin
    if (imemWe) imem[imemAddr] <= imemData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      pc    <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_RUN;
          pc    <= '0;
        end
        S_RUN: begin
          if (pc == LAST_PC) state <= S_FIN;
          else               pc    <= pc + 1'b1;
        end
        S_FIN: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadIn  = (state == S_IDLE) && start;
    strobe.exec    = (state == S_RUN);
    strobe.capture = (state == S_FIN);
    strobe.word    = microWord_t'(imem[pc]);
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  fin_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FIN) |=> done);

  // R10
  pc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && pc != LAST_PC) |=> (state == S_RUN && pc == $past(pc) + 1'b1));

endmodule

// File: rtl/ctlseq_dp.sv
module ctlseq_dp
  import ctlseq_pkg::*;
#(
  parameter q16_t KI      = 32'sh0000_8000,
  parameter q16_t KD      = 32'sh0000_4000,
  parameter q16_t KF      = 32'sh0000_C000,
  parameter q16_t KP      = 32'sh0002_0000,
  parameter q16_t MIN_LIM = 32'shFF9C_0000,
  parameter q16_t MAX_LIM = 32'sh0064_0000,
  localparam int NREG = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  q16_t       wIn,
  input  q16_t       yIn,
  output q16_t       pwmOut
);

  q16_t aVar  [NREG];
  q16_t bVar  [NREG];
  q16_t aView [NREG];
  q16_t bView [NREG];

  microWord_t  word;
  q16_t        opA, opB, aluRes;
  logic        opWrites;
  logic [32:0] sum;
  logic [47:0] prodScaled;
  destSlot_t   slot;
  logic        writeA, writeB;

  // constant registers overlay the variable banks
  always_comb begin
    aView     = aVar;
    bView     = bVar;
    aView[0]  = '0;
    bView[0]  = '0;
    aView[1]  = KI;
    aView[2]  = KD;
    aView[3]  = KF;
    aView[4]  = KP;
    aView[11] = Q_NEG_ONE;
    aView[12] = Q_ONE;
    aView[13] = '0;
    bView[12] = Q_NEG_ONE;
    bView[13] = Q_ONE;
    bView[14] = '0;
  end

  assign word = strobe.word;
  assign opA  = aView[word.aSel];
  assign opB  = bView[word.bSel];

  assign sum        = {opA[31], opA} + {opB[31], opB};
  assign prodScaled = 48'(({{32{opA[31]}}, opA} * {{32{opB[31]}}, opB}) >> 16);

  always_comb begin
    aluRes   = '0;
    opWrites = 1'b1;
    case (word.op)
      OP_ADD: begin
        if (sum[32] != sum[31]) aluRes = sum[32] ? Q_NEG_MAX : Q_POS_MAX;
        else                    aluRes = q16_t'(sum[31:0]);
      end
      OP_MUL: begin
        if (prodScaled[47:31] != {17{prodScaled[47]}})
          aluRes = prodScaled[47] ? Q_NEG_MAX : Q_POS_MAX;
        else
          aluRes = q16_t'(prodScaled[31:0]);
      end
      OP_SAT: begin
        if (opB < MIN_LIM)      aluRes = MIN_LIM;
        else if (opB > MAX_LIM) aluRes = MAX_LIM;
        else                    aluRes = opB;
      end
      OP_PASSA: aluRes = opA;
      OP_PASSB: aluRes = opB;
      default:  opWrites = 1'b0;
    endcase
  end

  assign slot   = mapDest(word.dest);
  assign writeA = strobe.exec && opWrites && slot.valid &&  slot.toA;
  assign writeB = strobe.exec && opWrites && slot.valid && !slot.toA;

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        aVar[g] <= '0;
        bVar[g] <= '0;
      end else begin
        if (strobe.loadIn && g == 5)      aVar[g] <= wIn;
        else if (strobe.loadIn && g == 6) aVar[g] <= yIn;
        else if (writeA && slot.idx == 4'(g)) aVar[g] <= aluRes;
        if (writeB && slot.idx == 4'(g))  bVar[g] <= aluRes;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               pwmOut <= '0;
    else if (strobe.capture) pwmOut <= bView[1];
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.exec && word.op == OP_ADD && !opA[31] && !opB[31]) |-> !aluRes[31]);

  // R5
  sat_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.exec && word.op == OP_SAT) |-> (aluRes >= MIN_LIM && aluRes <= MAX_LIM));

  // R7
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.exec && (word.op == OP_NOP || word.op > OP_PASSB)) |=> $stable(bVar[1]));

  // R2
  pwm_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(pwmOut));

endmodule

// File: rtl/ctlseq_top.sv
module ctlseq_top
  import ctlseq_pkg::*;
#(
  parameter int   NUM_INSTR  = 22,
  parameter int   IMEM_DEPTH = 32,
  parameter q16_t KI      = 32'sh0000_8000,
  parameter q16_t KD      = 32'sh0000_4000,
  parameter q16_t KF      = 32'sh0000_C000,
  parameter q16_t KP      = 32'sh0002_0000,
  parameter q16_t MIN_LIM = 32'shFF9C_0000,
  parameter q16_t MAX_LIM = 32'sh0064_0000,
  localparam int AW = $clog2(IMEM_DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [31:0]   wIn,
  input  logic [31:0]   yIn,
  input  logic          imemWe,
  input  logic [AW-1:0] imemAddr,
  input  logic [15:0]   imemData,
  output logic [31:0]   pwmOut,
  output logic          done
);

  ctlStrobe_t strobe;

  ctlseq_ctrl #(
    .NUM_INSTR (NUM_INSTR),
    .IMEM_DEPTH(IMEM_DEPTH)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .imemWe  (imemWe),
    .imemAddr(imemAddr),
    .imemData(imemData),
    .strobe  (strobe),
    .done    (done)
  );

  ctlseq_dp #(
    .KI(KI), .KD(KD), .KF(KF), .KP(KP),
    .MIN_LIM(MIN_LIM), .MAX_LIM(MAX_LIM)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wIn   (wIn),
    .yIn   (yIn),
    .pwmOut(pwmOut)
  );

endmodule

// File: tb/sim_ctlseq_top.sv
module sim_ctlseq_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_INSTR  = 22;
  localparam int IMEM_DEPTH = 32;
  localparam int AW = $clog2(IMEM_DEPTH);
  localparam logic [31:0] KI_Q   = 32'h0000_8000;
  localparam logic [31:0] KP_Q   = 32'h0002_0000;
  localparam logic [31:0] MIN_Q  = 32'hFF9C_0000;
  localparam logic [31:0] MAX_Q  = 32'h0064_0000;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] w;
    logic [31:0] y;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{4'd1, 32'h0001_8000, 32'h0002_4000, 32'h0003_C000},
    '{4'd1, 32'h7FFF_0000, 32'h0002_0000, 32'h7FFF_FFFF},
    '{4'd1, 32'h8001_0000, 32'hFFFE_0000, 32'h8000_0000},
    '{4'd2, 32'h0001_8000, 32'hFFFE_0000, 32'hFFFD_0000},
    '{4'd2, 32'h0000_8000, 32'h0000_8000, 32'h0000_4000},
    '{4'd2, 32'h0100_0000, 32'h0100_0000, 32'h7FFF_FFFF},
    '{4'd3, 32'h0000_0000, 32'h0096_0000, 32'h0064_0000},
    '{4'd3, 32'h0000_0000, 32'hFF38_0000, 32'hFF9C_0000},
    '{4'd3, 32'h0000_0000, 32'hFFFC_8000, 32'hFFFC_8000},
    '{4'd3, 32'h0000_0000, 32'h0064_0000, 32'h0064_0000},
    '{4'd4, 32'h1234_5678, 32'h0000_0001, 32'h1234_5678},
    '{4'd5, 32'h0000_0002, 32'hCAFE_0001, 32'hCAFE_0001}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [31:0]   wIn = '0;
  logic [31:0]   yIn = '0;
  logic          imemWe = 1'b0;
  logic [AW-1:0] imemAddr = '0;
  logic [15:0]   imemData = '0;
  logic [31:0]   pwmOut;
  logic          done;

  int totalChecks = 0;
  int failChecks  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ctlseq_top #(
    .NUM_INSTR(NUM_INSTR), .IMEM_DEPTH(IMEM_DEPTH),
    .KI(KI_Q), .KD(32'h0000_4000), .KF(32'h0000_C000), .KP(KP_Q),
    .MIN_LIM(MIN_Q), .MAX_LIM(MAX_Q)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .wIn(wIn), .yIn(yIn),
    .imemWe(imemWe), .imemAddr(imemAddr), .imemData(imemData),
    .pwmOut(pwmOut), .done(done)
  );

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [15:0] mw(input int a, input int b, input int d, input int o);
    return {4'(a), 4'(b), 4'(d), 4'(o)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    totalChecks++;
    if (act !== exp) begin
      failChecks++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic putInstr(input int addr, input logic [15:0] word);
    @(negedge clk);
    imemWe   = 1'b1;
    imemAddr = AW'(addr);
    imemData = word;
    @(negedge clk);
    imemWe   = 1'b0;
  endtask

  task automatic clearProg();
    for (int i = 0; i < IMEM_DEPTH; i++) putInstr(i, 16'h0000);
  endtask

  // returns negedges from start drive until done is seen
  task automatic runSeq(input logic [31:0] w, input logic [31:0] y, output int lat);
    @(negedge clk);
    start = 1'b1;
    wIn   = w;
    yIn   = y;
    @(negedge clk);
    start = 1'b0;
    lat   = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failChecks++;
    totalChecks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end

  initial begin
    int lat;
    int doneCount;

    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", pwmOut, 32'h0);
    check("R1", {31'h0, done}, 32'h0);
    rstN = 1'b1;

    // table: move Y to B6, then A5 op B6 -> B1 (R2 loads, R11 rewrites)
    clearProg();
    putInstr(0, mw(6, 0, 3, 4));
    for (int i = 0; i < 12; i++) begin
      putInstr(1, mw(5, 6, 2, int'(VECS[i].op)));
      runSeq(VECS[i].w, VECS[i].y, lat);
      check(reqOf(VECS[i].op), pwmOut, VECS[i].exp);
      if (i == 0) begin
        // R2 latency and pulse width
        check("R2", 32'(lat), 32'(NUM_INSTR + 2));
        @(negedge clk);
        check("R2", {31'h0, done}, 32'h0);
      end
    end

    // R7 no-write operators leave B1 holding the last result
    putInstr(1, mw(5, 6, 2, 0));
    runSeq(32'h0000_1111, 32'h0000_2222, lat);
    check("R7", pwmOut, 32'hCAFE_0001);
    putInstr(1, mw(5, 6, 2, 9));
    runSeq(32'h0000_1111, 32'h0000_2222, lat);
    check("R7", pwmOut, 32'hCAFE_0001);
    // R8 destination code 15 writes nothing
    putInstr(1, mw(5, 6, 15, 4));
    runSeq(32'h0000_1111, 32'h0000_2222, lat);
    check("R8", pwmOut, 32'hCAFE_0001);

    // R8 and R9: back-to-back chain through every destination code
    clearProg();
    putInstr(0,  mw(5, 0, 4, 4));
    putInstr(1,  mw(7, 0, 0, 4));
    putInstr(2,  mw(0, 8, 5, 5));
    putInstr(3,  mw(8, 0, 1, 4));
    putInstr(4,  mw(0, 7, 6, 5));
    putInstr(5,  mw(9, 0, 7, 4));
    putInstr(6,  mw(0, 2, 11, 5));
    putInstr(7,  mw(10, 0, 8, 4));
    putInstr(8,  mw(0, 3, 13, 5));
    putInstr(9,  mw(0, 4, 14, 5));
    putInstr(10, mw(0, 5, 9, 5));
    putInstr(11, mw(0, 9, 10, 5));
    putInstr(12, mw(0, 10, 12, 5));
    putInstr(13, mw(0, 11, 3, 5));
    putInstr(14, mw(0, 6, 2, 5));
    runSeq(32'h0003_1234, 32'h0000_0000, lat);
    check("R8", pwmOut, 32'h0003_1234);
    check("R9", 32'(lat), 32'(NUM_INSTR + 2));

    // R12 subtraction via -1 constant
    clearProg();
    putInstr(0, mw(6, 0, 3, 4));
    putInstr(1, mw(11, 6, 3, 2));
    putInstr(2, mw(5, 6, 2, 1));
    runSeq(32'h0005_0000, 32'h0001_4000, lat);
    check("R12", pwmOut, 32'h0003_C000);
    // R12 integral gain times +1
    clearProg();
    putInstr(0, mw(1, 13, 2, 2));
    runSeq(32'h0, 32'h0, lat);
    check("R12", pwmOut, KI_Q);
    // R12 proportional gain times -1
    putInstr(0, mw(4, 12, 2, 2));
    runSeq(32'h0, 32'h0, lat);
    check("R12", pwmOut, 32'hFFFE_0000);

    // R10 start during a run is ignored
    clearProg();
    putInstr(NUM_INSTR - 1, mw(5, 0, 2, 4));
    @(negedge clk);
    start = 1'b1;
    wIn   = 32'h0001_0000;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1;
    wIn   = 32'h0009_0000;
    @(negedge clk);
    start = 1'b0;
    doneCount = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done) doneCount++;
    end
    check("R10", pwmOut, 32'h0001_0000);
    check("R10", 32'(doneCount), 32'd1);

    // R11 rewrite the last word: same inputs give a different result
    putInstr(NUM_INSTR - 1, mw(6, 0, 2, 4));
    runSeq(32'h0001_0000, 32'h0007_0000, lat);
    check("R11", pwmOut, 32'h0007_0000);

    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end

endmodule